// File: doc/BRIEF.md
# Non-Blocking Miss Status Tracker

This block sits beside a data cache and keeps track of line refills that are still outstanding, so that a miss never stalls the lookup path. Each lookup result from the tag array falls into one of three classes. A hit passes straight through. A primary miss claims a free tracking entry and raises one refill request toward the next memory level. A secondary miss targets a line that already has an entry: it is attached to that entry, and it neither starts a refill nor returns data at once. When the refill data returns, the tracker emits one wakeup per waiting requester, in arrival order, and then frees the entry.

Dirty victims chosen by the cache are parked in a small writeback buffer. The buffer drains toward memory on its own handshake, independently of the refills. A refill for a line that still sits in that buffer is held back until the writeback has left, so the lower level never returns a stale copy. Prefetch hints use the same path as demand misses. They never ask for a retry and never produce a wakeup.

Top module: `mshr_tracker`

## Requirements
- R1: A lookup marked as a hit never raises `lk_retry` or `lk_secondary` and changes no tracker state, even while refills are outstanding.
- R2: A demand miss whose line (the address with its low 6 bits dropped) has no entry, while a free entry exists, takes that entry and leads to exactly one refill request carrying that line. Up to `N_ENT` distinct lines may be outstanding at once, and each line has at most one entry.
- R3: A demand miss to a line that already has an entry raises `lk_secondary`, appends the requester id to that entry, and issues no further refill request.
- R4: A demand miss raises `lk_retry` and is not recorded if it needs a new entry while every entry is busy, or if it targets an entry whose merge list already holds `MERGE_D` ids.
- R5: A refill request for a line held in the writeback buffer, or a line entering it in the same cycle, is withheld until that line's writeback handshake completes. Then the request is raised.
- R6: An eviction is accepted only while `ev_ready` is 1, which is the case when a buffer slot is free. Occupied slots are offered on the writeback port lowest slot first. Each slot is released by a `wb_req_valid`/`wb_req_ready` handshake, without regard to refill activity.
- R7: A prefetch never raises `lk_retry` or `lk_secondary`. It does nothing on a hit or when its line already has an entry. With no free entry it is dropped. Otherwise it takes an entry, requests the refill, and on completion frees the entry without a wakeup.
- R8: A refill response naming a line whose request has been sent produces one `wk_valid` cycle per recorded id. The first is the primary requester, then the secondaries in the order they arrived. The entry becomes free in the cycle after the last wakeup.
- R9: Two addresses that differ only in bits [5:0] address the same line for every match and request.
- R10: After reset no refill request, writeback request or wakeup is raised, and `ev_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | A lookup result is presented this cycle |
| lk_hit | input | 1 | The tag array found the line |
| lk_prefetch | input | 1 | The lookup is a prefetch hint, not a demand access |
| lk_addr | input | ADDR_W | Byte address of the lookup |
| lk_id | input | ID_W | Requester id, returned on wakeup |
| lk_retry | output | 1 | Demand miss could not be recorded; replay it later |
| lk_secondary | output | 1 | Demand miss was merged into an outstanding entry |
| ev_valid | input | 1 | A dirty victim line is offered |
| ev_addr | input | ADDR_W | Byte address of the victim line |
| ev_ready | output | 1 | The writeback buffer has a free slot |
| rf_req_valid | output | 1 | Refill request toward the next level |
| rf_req_line | output | ADDR_W-6 | Line address of the refill request |
| rf_req_ready | input | 1 | The next level accepts the refill request |
| rf_rsp_valid | input | 1 | Refill data for a line has arrived |
| rf_rsp_line | input | ADDR_W-6 | Line address of the refill response |
| wk_valid | output | 1 | Wakeup for a waiting requester |
| wk_id | output | ID_W | Id of the requester being woken |
| wb_req_valid | output | 1 | Writeback request toward the next level |
| wb_req_line | output | ADDR_W-6 | Line address being written back |
| wb_req_ready | input | 1 | The next level accepts the writeback |

## Verification
The bench goes after the points where the outcome class flips. The first is a miss that lands on a line with an entry, using a different byte offset. A design that compares the full address would issue a duplicate refill there. The second is the fifth distinct line while four are outstanding, and the fifth merge on one line. A design without those limits would overwrite a live entry or lose an id instead of asking for a retry. Wakeup order after a response is checked id by id, so a reversed merge list or a dropped primary shows up. A demand miss to a line parked in the writeback buffer is watched for several cycles. A design without the hazard check would send its refill at once, before the dirty data left. Prefetches that meet a full tracker, a pending line, or a free entry are each checked: a design that retries them, wakes anyone for them, or keeps a dropped one would be caught.

// File: rtl/mt_pkg.sv
package mt_pkg;

  // Life cycle of one tracking entry
  typedef enum logic [1:0] {
    ST_FREE  = 2'd0,  // unused
    ST_ISSUE = 2'd1,  // refill not yet sent
    ST_WAIT  = 2'd2,  // refill sent, data outstanding
    ST_DRAIN = 2'd3   // data back, wakeups being emitted
  } ent_st_e;

endpackage

// File: rtl/mt_entry.sv
module mt_entry
  import mt_pkg::*;
#(
  parameter int LINE_W  = 26,
  parameter int ID_W    = 4,
  parameter int MERGE_D = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_i,
  input  logic [LINE_W-1:0] line_i,
  input  logic              push_i,
  input  logic [ID_W-1:0]   push_id_i,
  input  logic              sent_i,
  input  logic              fill_i,
  input  logic              pop_i,
  output ent_st_e           st_o,
  output logic [LINE_W-1:0] line_o,
  output logic [ID_W-1:0]   head_o,
  output logic              has_id_o,
  output logic              full_o
);

  localparam int PW = (MERGE_D > 1) ? $clog2(MERGE_D) : 1;
  localparam int CW = $clog2(MERGE_D + 1);

  ent_st_e           st_q, st_d;
  logic [LINE_W-1:0] line_q, line_d;
  logic [PW-1:0]     rd_q, rd_d, wr_q, wr_d, wa;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic [ID_W-1:0]   ids_q [MERGE_D];

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == PW'(MERGE_D - 1)) ? '0 : p + PW'(1);
  endfunction

  // next state
  always_comb begin
    st_d   = st_q;
    line_d = line_q;
    rd_d   = rd_q;
    wr_d   = wr_q;
    cnt_d  = cnt_q;
    wa     = wr_q;
    if (alloc_i) begin
      st_d   = ST_ISSUE;
      line_d = line_i;
      rd_d   = '0;
      wa     = '0;
      wr_d   = push_i ? step('0) : '0;
      cnt_d  = push_i ? CW'(1) : '0;
    end else begin
      if (push_i) wr_d = step(wr_q);
      if (pop_i)  rd_d = step(rd_q);
      cnt_d = cnt_q + CW'(push_i) - CW'(pop_i);
      unique case (st_q)
        ST_ISSUE: if (sent_i) st_d = ST_WAIT;
        ST_WAIT:  if (fill_i) st_d = ST_DRAIN;
        ST_DRAIN: if (cnt_d == '0) st_d = ST_FREE;
        default:  ;
      endcase
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_FREE;
      line_q <= '0;
      rd_q   <= '0;
      wr_q   <= '0;
      cnt_q  <= '0;
    end else begin
      st_q  <= st_d;
      rd_q  <= rd_d;
      wr_q  <= wr_d;
      cnt_q <= cnt_d;
      if (alloc_i) line_q <= line_d;
    end
  end

  // id storage, written only through its enable
  always_ff @(posedge clk) begin
    if (push_i) ids_q[wa] <= push_id_i;
  end

  assign st_o     = st_q;
  assign line_o   = line_q;
  assign head_o   = ids_q[rd_q];
  assign has_id_o = (cnt_q != '0);
  assign full_o   = (cnt_q == CW'(MERGE_D));

endmodule

// File: rtl/mt_wbuf.sv
module mt_wbuf #(
  parameter int LINE_W = 26,
  parameter int WB_D   = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         ev_valid_i,
  input  logic [LINE_W-1:0]            ev_line_i,
  output logic                         ev_ready_o,
  output logic                         req_valid_o,
  output logic [LINE_W-1:0]            req_line_o,
  input  logic                         req_ready_i,
  output logic [WB_D-1:0]              slot_v_o,
  output logic [WB_D-1:0][LINE_W-1:0]  slot_line_o
);

  localparam int IW = (WB_D > 1) ? $clog2(WB_D) : 1;

  logic [WB_D-1:0]             v_q, v_d;
  logic [WB_D-1:0][LINE_W-1:0] line_q;
  logic [IW-1:0]               fidx, oidx;
  logic                        fany, oany, take, give;

  // lowest free slot and lowest occupied slot
  always_comb begin
    fany = 1'b0;
    fidx = '0;
    oany = 1'b0;
    oidx = '0;
    for (int j = WB_D - 1; j >= 0; j--) begin
      if (!v_q[j]) begin fany = 1'b1; fidx = IW'(j); end
      if (v_q[j])  begin oany = 1'b1; oidx = IW'(j); end
    end
  end

  assign take = ev_valid_i & fany;
  assign give = oany & req_ready_i;

  always_comb begin
    v_d = v_q;
    if (give) v_d[oidx] = 1'b0;
    if (take) v_d[fidx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q    <= '0;
      line_q <= '0;
    end else begin
      v_q <= v_d;
      if (take) line_q[fidx] <= ev_line_i;
    end
  end

  assign ev_ready_o  = fany;
  assign req_valid_o = oany;
  assign req_line_o  = line_q[oidx];
  assign slot_v_o    = v_q;
  assign slot_line_o = line_q;

endmodule

// File: rtl/mshr_tracker.sv
module mshr_tracker
  import mt_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int OFF_W   = 6,
  parameter int ID_W    = 4,
  parameter int N_ENT   = 4,
  parameter int MERGE_D = 4,
  parameter int WB_D    = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      lk_valid,
  input  logic                      lk_hit,
  input  logic                      lk_prefetch,
  input  logic [ADDR_W-1:0]         lk_addr,
  input  logic [ID_W-1:0]           lk_id,
  output logic                      lk_retry,
  output logic                      lk_secondary,
  input  logic                      ev_valid,
  input  logic [ADDR_W-1:0]         ev_addr,
  output logic                      ev_ready,
  output logic                      rf_req_valid,
  output logic [ADDR_W-OFF_W-1:0]   rf_req_line,
  input  logic                      rf_req_ready,
  input  logic                      rf_rsp_valid,
  input  logic [ADDR_W-OFF_W-1:0]   rf_rsp_line,
  output logic                      wk_valid,
  output logic [ID_W-1:0]           wk_id,
  output logic                      wb_req_valid,
  output logic [ADDR_W-OFF_W-1:0]   wb_req_line,
  input  logic                      wb_req_ready
);

  localparam int LINE_W = ADDR_W - OFF_W;
  localparam int EW     = (N_ENT > 1) ? $clog2(N_ENT) : 1;

  logic [LINE_W-1:0]             lk_line, ev_line;
  logic [2*OFF_W-1:0]            unused_offsets;

  ent_st_e                       ent_st   [N_ENT];
  logic [ID_W-1:0]               ent_head [N_ENT];
  logic [N_ENT-1:0][LINE_W-1:0]  ent_line;
  logic [N_ENT-1:0]              ent_has, ent_full, ent_busy, blocked;
  logic [N_ENT-1:0]              ent_alloc, ent_push, ent_sent, ent_fill, ent_pop;

  logic [WB_D-1:0]               wb_v;
  logic [WB_D-1:0][LINE_W-1:0]   wb_lines;

  logic                          miss, demand;
  logic                          hit_any, free_any, iss_any, drn_any;
  logic [EW-1:0]                 hit_idx, free_idx, iss_idx, drn_idx;
  logic                          merge_ok, alloc_ok;

  // line addresses: byte offset dropped
  assign lk_line        = lk_addr[ADDR_W-1:OFF_W];
  assign ev_line        = ev_addr[ADDR_W-1:OFF_W];
  assign unused_offsets = {lk_addr[OFF_W-1:0], ev_addr[OFF_W-1:0]};

  // lookup classification
  assign miss   = lk_valid & ~lk_hit;
  assign demand = miss & ~lk_prefetch;

  // a line held in the writeback buffer (or entering it) blocks its refill
  always_comb begin
    for (int i = 0; i < N_ENT; i++) begin
      blocked[i] = ev_valid && ev_ready && (ev_line == ent_line[i]);
      for (int j = 0; j < WB_D; j++) begin
        if (wb_v[j] && (wb_lines[j] == ent_line[i])) blocked[i] = 1'b1;
      end
    end
  end

  // priority picks, lowest index wins
  always_comb begin
    hit_any  = 1'b0; hit_idx  = '0;
    free_any = 1'b0; free_idx = '0;
    iss_any  = 1'b0; iss_idx  = '0;
    drn_any  = 1'b0; drn_idx  = '0;
    for (int i = N_ENT - 1; i >= 0; i--) begin
      if (ent_busy[i] && (ent_line[i] == lk_line)) begin
        hit_any = 1'b1; hit_idx = EW'(i);
      end
      if (!ent_busy[i]) begin
        free_any = 1'b1; free_idx = EW'(i);
      end
      if ((ent_st[i] == ST_ISSUE) && !blocked[i]) begin
        iss_any = 1'b1; iss_idx = EW'(i);
      end
      if ((ent_st[i] == ST_DRAIN) && ent_has[i]) begin
        drn_any = 1'b1; drn_idx = EW'(i);
      end
    end
  end

  assign merge_ok     = demand & hit_any & ~ent_full[hit_idx];
  assign alloc_ok     = miss & ~hit_any & free_any;
  assign lk_retry     = demand & (hit_any ? ent_full[hit_idx] : ~free_any);
  assign lk_secondary = merge_ok;

  assign rf_req_valid = iss_any;
  assign rf_req_line  = ent_line[iss_idx];
  assign wk_valid     = drn_any;
  assign wk_id        = ent_head[drn_idx];

  // per-entry strobes
  always_comb begin
    for (int i = 0; i < N_ENT; i++) begin
      ent_alloc[i] = alloc_ok && (free_idx == EW'(i));
      ent_push[i]  = (ent_alloc[i] && demand) || (merge_ok && (hit_idx == EW'(i)));
      ent_sent[i]  = rf_req_valid && rf_req_ready && (iss_idx == EW'(i));
      ent_fill[i]  = rf_rsp_valid && (ent_st[i] == ST_WAIT) && (ent_line[i] == rf_rsp_line);
      ent_pop[i]   = wk_valid && (drn_idx == EW'(i));
    end
  end

  for (genvar g = 0; g < N_ENT; g++) begin : g_ent
    mt_entry #(
      .LINE_W  (LINE_W),
      .ID_W    (ID_W),
      .MERGE_D (MERGE_D)
    ) u_ent (
      .clk       (clk),
      .rst_n     (rst_n),
      .alloc_i   (ent_alloc[g]),
      .line_i    (lk_line),
      .push_i    (ent_push[g]),
      .push_id_i (lk_id),
      .sent_i    (ent_sent[g]),
      .fill_i    (ent_fill[g]),
      .pop_i     (ent_pop[g]),
      .st_o      (ent_st[g]),
      .line_o    (ent_line[g]),
      .head_o    (ent_head[g]),
      .has_id_o  (ent_has[g]),
      .full_o    (ent_full[g])
    );
    assign ent_busy[g] = (ent_st[g] != ST_FREE);
  end

  mt_wbuf #(
    .LINE_W (LINE_W),
    .WB_D   (WB_D)
  ) u_wbuf (
    .clk         (clk),
    .rst_n       (rst_n),
    .ev_valid_i  (ev_valid),
    .ev_line_i   (ev_line),
    .ev_ready_o  (ev_ready),
    .req_valid_o (wb_req_valid),
    .req_line_o  (wb_req_line),
    .req_ready_i (wb_req_ready),
    .slot_v_o    (wb_v),
    .slot_line_o (wb_lines)
  );

endmodule

// File: rtl/mt_chk.sv
module mt_chk #(
  parameter int N_ENT  = 4,
  parameter int LINE_W = 26
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      lk_valid,
  input logic                      lk_hit,
  input logic                      lk_prefetch,
  input logic                      lk_retry,
  input logic                      lk_secondary,
  input logic                      rf_req_valid,
  input logic [LINE_W-1:0]         rf_req_line,
  input logic                      wb_req_valid,
  input logic [LINE_W-1:0]         wb_req_line,
  input logic [N_ENT-1:0]          busy,
  input logic [N_ENT-1:0][LINE_W-1:0] lines
);

  logic dup;

  always_comb begin
    dup = 1'b0;
    for (int a = 0; a < N_ENT; a++) begin
      for (int b = a + 1; b < N_ENT; b++) begin
        if (busy[a] && busy[b] && (lines[a] == lines[b])) dup = 1'b1;
      end
    end
  end

  // R1: hits are never retried or merged
  a_r1_hit_passes: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_hit) |-> (!lk_retry && !lk_secondary));

  // R2: one entry per line
  a_r2_one_entry_per_line: assert property (@(posedge clk) disable iff (!rst_n)
    !dup);

  // R3 / R4: a lookup is either merged or retried, never both
  a_r3_merge_or_retry: assert property (@(posedge clk) disable iff (!rst_n)
    !(lk_secondary && lk_retry));

  // R4: only demand misses are retried
  a_r4_retry_demand_only: assert property (@(posedge clk) disable iff (!rst_n)
    lk_retry |-> (lk_valid && !lk_hit && !lk_prefetch));

  // R5: no refill of a line whose writeback is on offer
  a_r5_no_stale_refill: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_req_valid && wb_req_valid) |-> (rf_req_line != wb_req_line));

  // R7: prefetches are neither retried nor merged
  a_r7_prefetch_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_prefetch) |-> (!lk_retry && !lk_secondary));

endmodule

bind mshr_tracker mt_chk #(
  .N_ENT  (N_ENT),
  .LINE_W (LINE_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .lk_valid     (lk_valid),
  .lk_hit       (lk_hit),
  .lk_prefetch  (lk_prefetch),
  .lk_retry     (lk_retry),
  .lk_secondary (lk_secondary),
  .rf_req_valid (rf_req_valid),
  .rf_req_line  (rf_req_line),
  .wb_req_valid (wb_req_valid),
  .wb_req_line  (wb_req_line),
  .busy         (ent_busy),
  .lines        (ent_line)
);

// File: tb/sim_mshr_tracker.sv
module sim_mshr_tracker;

  localparam int AW = 32;
  localparam int LW = 26;
  localparam int IW = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          lk_valid, lk_hit, lk_prefetch;
  logic [AW-1:0] lk_addr;
  logic [IW-1:0] lk_id;
  logic          lk_retry, lk_secondary;
  logic          ev_valid;
  logic [AW-1:0] ev_addr;
  logic          ev_ready;
  logic          rf_req_valid;
  logic [LW-1:0] rf_req_line;
  logic          rf_req_ready;
  logic          rf_rsp_valid;
  logic [LW-1:0] rf_rsp_line;
  logic          wk_valid;
  logic [IW-1:0] wk_id;
  logic          wb_req_valid;
  logic [LW-1:0] wb_req_line;
  logic          wb_req_ready;

  int  n_chk = 0;
  int  n_fail = 0;
  bit  done = 1'b0;
  logic s_retry, s_sec, s_evr;

  always #2 clk = ~clk;

  mshr_tracker u0 (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_hit(lk_hit), .lk_prefetch(lk_prefetch),
    .lk_addr(lk_addr), .lk_id(lk_id),
    .lk_retry(lk_retry), .lk_secondary(lk_secondary),
    .ev_valid(ev_valid), .ev_addr(ev_addr), .ev_ready(ev_ready),
    .rf_req_valid(rf_req_valid), .rf_req_line(rf_req_line), .rf_req_ready(rf_req_ready),
    .rf_rsp_valid(rf_rsp_valid), .rf_rsp_line(rf_rsp_line),
    .wk_valid(wk_valid), .wk_id(wk_id),
    .wb_req_valid(wb_req_valid), .wb_req_line(wb_req_line), .wb_req_ready(wb_req_ready)
  );

  function automatic logic [LW-1:0] line_of(input logic [AW-1:0] a);
    return a[AW-1:6];
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic lk(input logic hit, input logic pf, input logic [AW-1:0] a, input logic [IW-1:0] id);
    @(negedge clk);
    lk_valid = 1'b1; lk_hit = hit; lk_prefetch = pf; lk_addr = a; lk_id = id;
    #1;
    s_retry = lk_retry;
    s_sec   = lk_secondary;
    @(posedge clk);
    #1;
    lk_valid = 1'b0;
  endtask

  task automatic take_rf(input logic [LW-1:0] exp, input string req);
    @(negedge clk);
    #1;
    chk(rf_req_valid && rf_req_line == exp, req, {rf_req_valid, rf_req_line}, {1'b1, exp});
    rf_req_ready = 1'b1;
    @(posedge clk);
    #1;
    rf_req_ready = 1'b0;
  endtask

  task automatic take_wb(input logic [LW-1:0] exp, input string req);
    @(negedge clk);
    #1;
    chk(wb_req_valid && wb_req_line == exp, req, {wb_req_valid, wb_req_line}, {1'b1, exp});
    wb_req_ready = 1'b1;
    @(posedge clk);
    #1;
    wb_req_ready = 1'b0;
  endtask

  task automatic evict(input logic [AW-1:0] a);
    @(negedge clk);
    ev_valid = 1'b1; ev_addr = a;
    #1;
    s_evr = ev_ready;
    @(posedge clk);
    #1;
    ev_valid = 1'b0;
  endtask

  // ids[3:0] is the first expected wakeup, ids[7:4] the second, ...
  task automatic respond(input logic [LW-1:0] line, input int n, input logic [15:0] ids, input string req);
    @(negedge clk);
    rf_rsp_valid = 1'b1; rf_rsp_line = line;
    @(posedge clk);
    #1;
    rf_rsp_valid = 1'b0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      #1;
      chk(wk_valid && wk_id == ids[k*4 +: 4], req, {wk_valid, wk_id}, {1'b1, ids[k*4 +: 4]});
    end
    @(negedge clk);
    #1;
    chk(!wk_valid, req, wk_valid, 0);
  endtask

  task automatic quiet_rf(input string req);
    @(negedge clk);
    #1;
    chk(!rf_req_valid, req, rf_req_valid, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] a, a2, h;
    void'($urandom(32'd4242));
    rst_n = 1'b0;
    lk_valid = 0; lk_hit = 0; lk_prefetch = 0; lk_addr = '0; lk_id = '0;
    ev_valid = 0; ev_addr = '0; rf_req_ready = 0; rf_rsp_valid = 0; rf_rsp_line = '0;
    wb_req_ready = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R10 reset state
    @(negedge clk); #1;
    chk(!rf_req_valid && !wb_req_valid && !wk_valid && ev_ready, "R10",
        {rf_req_valid, wb_req_valid, wk_valid, ev_ready}, 4'b0001);

    // R2 primary miss
    lk(0, 0, 32'h1000, 4'd1);
    chk(!s_retry && !s_sec, "R2", {s_retry, s_sec}, 0);
    take_rf(26'h40, "R2");

    // R1 hit while the miss is outstanding
    lk(1, 0, 32'h2000, 4'd15);
    chk(!s_retry && !s_sec, "R1", {s_retry, s_sec}, 0);
    quiet_rf("R1");

    // R3 / R9 secondary misses at other byte offsets
    lk(0, 0, 32'h1024, 4'd2);
    chk(s_sec && !s_retry, "R3", {s_sec, s_retry}, 2'b10);
    lk(0, 0, 32'h103F, 4'd3);
    chk(s_sec && !s_retry, "R9", {s_sec, s_retry}, 2'b10);
    quiet_rf("R3");

    // R7 prefetch to a pending line does nothing
    lk(0, 1, 32'h1000, 4'd0);
    chk(!s_sec && !s_retry, "R7", {s_sec, s_retry}, 0);
    quiet_rf("R7");

    // R2 fill all entries
    lk(0, 0, 32'h3000, 4'd4);
    chk(!s_sec && !s_retry, "R2", {s_sec, s_retry}, 0);
    take_rf(26'hC0, "R2");
    lk(0, 0, 32'h4000, 4'd5);
    take_rf(26'h100, "R2");
    lk(0, 0, 32'h5000, 4'd6);
    take_rf(26'h140, "R2");

    // R4 no free entry
    lk(0, 0, 32'h6000, 4'd7);
    chk(s_retry && !s_sec, "R4", {s_retry, s_sec}, 2'b10);
    quiet_rf("R4");

    // R7 prefetch with no free entry is dropped quietly
    lk(0, 1, 32'h6000, 4'd0);
    chk(!s_retry && !s_sec, "R7", {s_retry, s_sec}, 0);

    // R8 wakeups in arrival order
    respond(26'h40, 3, {4'd0, 4'd3, 4'd2, 4'd1}, "R8");
    quiet_rf("R7");

    // R2 freed entry reused
    lk(0, 0, 32'h6000, 4'd8);
    chk(!s_retry && !s_sec, "R2", {s_retry, s_sec}, 0);
    take_rf(26'h180, "R2");

    // R4 merge list full
    lk(0, 0, 32'h3008, 4'd9);
    lk(0, 0, 32'h3010, 4'd10);
    lk(0, 0, 32'h3018, 4'd11);
    chk(s_sec && !s_retry, "R3", {s_sec, s_retry}, 2'b10);
    lk(0, 0, 32'h3020, 4'd12);
    chk(s_retry && !s_sec, "R4", {s_retry, s_sec}, 2'b10);
    respond(26'hC0, 4, {4'd11, 4'd10, 4'd9, 4'd4}, "R8");
    respond(26'h100, 1, {12'd0, 4'd5}, "R8");
    respond(26'h140, 1, {12'd0, 4'd6}, "R8");
    respond(26'h180, 1, {12'd0, 4'd8}, "R8");

    // R5 writeback hazard
    evict(32'h8000);
    chk(s_evr, "R6", s_evr, 1);
    lk(0, 0, 32'h8010, 4'd13);
    chk(!s_retry && !s_sec, "R5", {s_retry, s_sec}, 0);
    quiet_rf("R5");
    quiet_rf("R5");
    quiet_rf("R5");
    take_wb(26'h200, "R6");
    take_rf(26'h200, "R5");
    respond(26'h200, 1, {12'd0, 4'd13}, "R8");

    // R6 writeback buffer full, lowest slot first
    evict(32'h9000);
    chk(s_evr, "R6", s_evr, 1);
    evict(32'hB000);
    chk(s_evr, "R6", s_evr, 1);
    evict(32'hC000);
    chk(!s_evr, "R6", s_evr, 0);
    take_wb(26'h240, "R6");
    take_wb(26'h2C0, "R6");
    @(negedge clk); #1;
    chk(!wb_req_valid && ev_ready, "R6", {wb_req_valid, ev_ready}, 2'b01);

    // R7 prefetch that allocates: refill but no wakeup
    lk(0, 1, 32'hA000, 4'd0);
    chk(!s_retry && !s_sec, "R7", {s_retry, s_sec}, 0);
    take_rf(26'h280, "R7");
    respond(26'h280, 0, 16'd0, "R7");

    // random phase: random offsets, random hits in between
    for (int it = 0; it < 24; it++) begin
      a  = 32'h0010_0000 + (it << 12) + ($urandom % 4096);
      a2 = {a[AW-1:6], 6'($urandom)};
      h  = $urandom;
      lk(0, 0, a, 4'(it));
      chk(!s_retry && !s_sec, "R2", {s_retry, s_sec}, 0);
      lk(1, 0, h, 4'd15);
      chk(!s_retry && !s_sec, "R1", {s_retry, s_sec}, 0);
      take_rf(line_of(a), "R9");
      lk(0, 0, a2, ~4'(it));
      chk(s_sec && !s_retry, "R9", {s_sec, s_retry}, 2'b10);
      respond(line_of(a), 2, {8'd0, ~4'(it), 4'(it)}, "R8");
    end
    quiet_rf("R2");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule